// File: doc/BRIEF.md
# Static Memory Bus Controller

This block lets a 32-bit host port reach an asynchronous static memory whose data bus is only 16 bits wide, spread over two chip-select banks. One host address bit picks the bank. Each bank keeps its own read wait-state count, write wait-state count and output-enable delay. These are loaded through a small register port, and the values take effect on transfers that start after they are written.

A host transfer is accepted in a cycle where both the request and ready are high. Ready then stays low while the block drives the external strobes. A 32-bit transfer becomes two 16-bit external cycles, the lower half-word first, and the halves are merged into a single 32-bit result. Chip-select always goes high for at least one cycle between external cycles, so the memory sees a separate access each time.

The reset values select the slowest timing (31 wait-states on both reads and writes, output-enable with no delay). A slow part therefore works correctly before software tunes the banks.

Top module: `stmem_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, host_ready is 1, both mem_cs_n bits are 1, and mem_oe_n and mem_we_n are 1. Every bank's read and write wait fields read back 31 and its output-enable delay reads back 0.
- R2: cfg_field selects the register of bank cfg_bank: 0 is the 5-bit read wait, 1 is the 5-bit write wait, 2 is the output-enable delay (cfg_wdata bits 3:0). Code 3 has no register: a write with code 3 changes nothing and a read with code 3 returns 0. cfg_rdata is combinational from cfg_bank and cfg_field.
- R3: host_addr bit BANK_BIT selects the bank. mem_cs_n[b] goes low only for bank b, and at most one bit of mem_cs_n is ever low.
- R4: A read external cycle holds chip-select low for exactly W+2 consecutive cycles, where W is the bank's read wait value (W=0 gives 2 cycles).
- R5: In a read cycle, mem_oe_n goes low in chip-select cycle D (counting the first chip-select cycle as 0), where D is the bank's output-enable delay and D is below W. It stays low up to and including the last chip-select cycle, and it is high whenever chip-select is high and during writes.
- R6: A write external cycle holds chip-select low for W+2 cycles (W = write wait). mem_we_n is low from the second chip-select cycle for max(W,1) cycles. mem_dout_en is 1 and mem_dout is stable for the whole chip-select period.
- R7: A 32-bit transfer (host_word=1) makes two external cycles. Their mem_addr is host_addr[BANK_BIT-1:2] with a half-word index of 0 and then 1 as its lowest bit. A 16-bit transfer makes one cycle at host_addr[BANK_BIT-1:1].
- R8: Half-word 0 carries data bits 15:0 and half-word 1 carries bits 31:16, for both writes and reads. A 16-bit read returns the memory word in host_rdata[15:0] with bits 31:16 zero. A 16-bit write drives host_wdata[15:0].
- R9: After an accepted request, host_ready is low for exactly N*(W+3) cycles, where N is 2 for 32-bit and 1 for 16-bit. When host_ready returns high, host_rdata holds the read result.
- R10: Chip-select stays high for at least one cycle between the two halves of a 32-bit transfer and between successive transfers. Chip-select never moves straight from one bank to the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_bank | input | 1 | Bank addressed by the configuration port |
| cfg_field | input | 2 | Register select: 0 read wait, 1 write wait, 2 OE delay, 3 none |
| cfg_wdata | input | 5 | Configuration write value |
| cfg_rdata | output | 5 | Configuration read value |
| host_req | input | 1 | Transfer request |
| host_wr | input | 1 | 1 write, 0 read |
| host_word | input | 1 | 1 for 32-bit, 0 for 16-bit |
| host_addr | input | BANK_BIT (bits BANK_BIT:1) | Byte address without bit 0; top bit is the bank |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | High when a request can be accepted or a transfer is complete |
| host_rdata | output | 32 | Read result |
| mem_cs_n | output | 2 | Active-low chip-select per bank |
| mem_oe_n | output | 1 | Active-low output-enable |
| mem_we_n | output | 1 | Active-low write-enable |
| mem_addr | output | BANK_BIT-1 | External half-word address |
| mem_dout | output | 16 | Data toward the memory |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | 16 | Data from the memory |

## Verification
The assertions check a number of pin-level rules on every cycle. At most one chip-select is low, and output-enable never sits outside chip-select. Write-enable only occurs with driven data, and a chip-select run never exceeds the longest legal access. Ready drops after an acceptance and is high with all strobes idle after reset. The exact access lengths, where output-enable starts, the write-enable span, the half-word addresses, the data merge and the stall length all depend on the programmed bank values. Only the bench scenarios can show these, by comparing every observed external cycle against a per-half expectation built from the configuration the bench wrote.

// File: rtl/stmem_pkg.sv
package stmem_pkg;

    localparam int WS_W      = 5;
    localparam int OED_W     = 4;
    localparam int MEM_DW    = 16;
    localparam int HOST_DW   = 2 * MEM_DW;
    localparam int NUM_BANKS = 2;
    localparam int BSEL_W    = $clog2(NUM_BANKS);
    localparam int CNT_W     = WS_W + 1;

    typedef logic [WS_W-1:0]  ws_t;
    typedef logic [OED_W-1:0] oed_t;
    typedef logic [CNT_W-1:0] cnt_t;

    localparam ws_t  WS_RESET  = '1;
    localparam oed_t OED_RESET = '0;

    typedef struct packed {
        ws_t  rd_ws;
        ws_t  wr_ws;
        oed_t oe_dly;
    } bank_cfg_t;

    typedef enum logic [1:0] {
        FLD_RD_WS  = 2'd0,
        FLD_WR_WS  = 2'd1,
        FLD_OE_DLY = 2'd2,
        FLD_NONE   = 2'd3
    } cfg_field_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ACCESS = 2'd1,
        SQ_GAP    = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [BSEL_W-1:0] bank;
        logic              wr;
        logic              word;
        ws_t               ws;
        oed_t              oed;
    } xfer_t;

    // index of the final chip-select cycle: wait value plus one
    function automatic cnt_t last_count(input ws_t ws);
        return {1'b0, ws} + cnt_t'(1);
    endfunction

    // number of write-enable cycles, never fewer than one
    function automatic cnt_t we_span(input ws_t ws);
        return (ws == '0) ? cnt_t'(1) : {1'b0, ws};
    endfunction

    function automatic cnt_t widen_oed(input oed_t d);
        return {{(CNT_W-OED_W){1'b0}}, d};
    endfunction

endpackage

// File: rtl/stmem_cfg_regs.sv
module stmem_cfg_regs
    import stmem_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [BSEL_W-1:0]       cfg_bank,
    input  logic [1:0]              cfg_field,
    input  logic [WS_W-1:0]         cfg_wdata,
    output logic [WS_W-1:0]         cfg_rdata,
    output bank_cfg_t [NUM_BANKS-1:0] bank_cfg
);

    cfg_field_e field;
    bank_cfg_t  rd_sel;

    assign field = cfg_field_e'(cfg_field);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                bank_cfg[b].rd_ws  <= WS_RESET;
                bank_cfg[b].wr_ws  <= WS_RESET;
                bank_cfg[b].oe_dly <= OED_RESET;
            end
        end else if (cfg_wr) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (cfg_bank == BSEL_W'(b)) begin
                    case (field)
                        FLD_RD_WS:  bank_cfg[b].rd_ws  <= cfg_wdata;
                        FLD_WR_WS:  bank_cfg[b].wr_ws  <= cfg_wdata;
                        FLD_OE_DLY: bank_cfg[b].oe_dly <= cfg_wdata[OED_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rd_sel = bank_cfg[cfg_bank];
        case (field)
            FLD_RD_WS:  cfg_rdata = rd_sel.rd_ws;
            FLD_WR_WS:  cfg_rdata = rd_sel.wr_ws;
            FLD_OE_DLY: cfg_rdata = {{(WS_W-OED_W){1'b0}}, rd_sel.oe_dly};
            default:    cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/stmem_seq.sv
module stmem_seq
    import stmem_pkg::*;
#(
    parameter int BANK_BIT = 20
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      host_req,
    input  logic                      host_wr,
    input  logic                      host_word,
    input  logic [BANK_BIT-1:0]       hw_addr,
    input  bank_cfg_t [NUM_BANKS-1:0] bank_cfg,
    output logic                      host_ready,
    output logic                      cs_act,
    output logic                      oe_act,
    output logic                      we_act,
    output logic                      capture,
    output logic                      half_idx,
    output logic [BSEL_W-1:0]         act_bank,
    output logic                      xfer_wr,
    output logic                      xfer_word,
    output logic [BANK_BIT-2:0]       half_addr
);

    seq_state_e        state;
    cnt_t              cnt;
    xfer_t             xfer;
    logic [BSEL_W-1:0] new_bank;
    bank_cfg_t         new_cfg;
    logic              at_last;

    // bank bit sits at the top of the half-word address slice
    assign new_bank = hw_addr[BANK_BIT-1 -: BSEL_W];
    assign new_cfg  = bank_cfg[new_bank];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            half_idx  <= 1'b0;
            xfer      <= '0;
            half_addr <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (host_req) begin
                        xfer.bank <= new_bank;
                        xfer.wr   <= host_wr;
                        xfer.word <= host_word;
                        xfer.ws   <= host_wr ? new_cfg.wr_ws : new_cfg.rd_ws;
                        xfer.oed  <= new_cfg.oe_dly;
                        half_addr <= hw_addr[BANK_BIT-2:0];
                        cnt       <= '0;
                        half_idx  <= 1'b0;
                        state     <= SQ_ACCESS;
                    end
                end
                SQ_ACCESS: begin
                    if (at_last) begin
                        state <= SQ_GAP;
                    end else begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
                SQ_GAP: begin
                    if (xfer.word && !half_idx) begin
                        half_idx <= 1'b1;
                        cnt      <= '0;
                        state    <= SQ_ACCESS;
                    end else begin
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        host_ready = (state == SQ_IDLE);
        cs_act     = (state == SQ_ACCESS);
        at_last    = cs_act && (cnt == last_count(xfer.ws));
        oe_act     = cs_act && !xfer.wr && (cnt >= widen_oed(xfer.oed));
        we_act     = cs_act && xfer.wr && (cnt != '0) && (cnt <= we_span(xfer.ws));
        capture    = at_last && !xfer.wr;
        act_bank   = xfer.bank;
        xfer_wr    = xfer.wr;
        xfer_word  = xfer.word;
    end

endmodule

// File: rtl/stmem_datapath.sv
module stmem_datapath
    import stmem_pkg::*;
#(
    parameter int BANK_BIT = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [HOST_DW-1:0]   host_wdata,
    input  logic [BANK_BIT-2:0]  half_addr,
    input  logic                 half_idx,
    input  logic                 xfer_word,
    input  logic                 capture,
    input  logic [MEM_DW-1:0]    mem_din,
    output logic [BANK_BIT-2:0]  mem_addr,
    output logic [MEM_DW-1:0]    mem_dout,
    output logic [HOST_DW-1:0]   host_rdata
);

    logic [HOST_DW-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
        end else if (start) begin
            wdata_q <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (capture) begin
            if (!half_idx) begin
                host_rdata[MEM_DW-1:0] <= mem_din;
                if (!xfer_word) begin
                    host_rdata[HOST_DW-1:MEM_DW] <= '0;
                end
            end else begin
                host_rdata[HOST_DW-1:MEM_DW] <= mem_din;
            end
        end
    end

    always_comb begin
        mem_addr = xfer_word ? {half_addr[BANK_BIT-2:1], half_idx} : half_addr;
        mem_dout = half_idx ? wdata_q[HOST_DW-1:MEM_DW] : wdata_q[MEM_DW-1:0];
    end

endmodule

// File: rtl/stmem_ctrl.sv
module stmem_ctrl
    import stmem_pkg::*;
#(
    parameter int BANK_BIT = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [BSEL_W-1:0]     cfg_bank,
    input  logic [1:0]            cfg_field,
    input  logic [WS_W-1:0]       cfg_wdata,
    output logic [WS_W-1:0]       cfg_rdata,
    input  logic                  host_req,
    input  logic                  host_wr,
    input  logic                  host_word,
    input  logic [BANK_BIT:1]     host_addr,
    input  logic [HOST_DW-1:0]    host_wdata,
    output logic                  host_ready,
    output logic [HOST_DW-1:0]    host_rdata,
    output logic [NUM_BANKS-1:0]  mem_cs_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [BANK_BIT-2:0]   mem_addr,
    output logic [MEM_DW-1:0]     mem_dout,
    output logic                  mem_dout_en,
    input  logic [MEM_DW-1:0]     mem_din
);

    bank_cfg_t [NUM_BANKS-1:0] bank_cfg;
    logic                      cs_act, oe_act, we_act, capture;
    logic                      half_idx, xfer_wr, xfer_word, start;
    logic [BSEL_W-1:0]         act_bank;
    logic [BANK_BIT-2:0]       half_addr;
    logic [BANK_BIT-1:0]       hw_addr;

    assign hw_addr = host_addr;
    assign start   = host_req && host_ready;

    stmem_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_bank  (cfg_bank),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bank_cfg  (bank_cfg)
    );

    stmem_seq #(.BANK_BIT(BANK_BIT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_word  (host_word),
        .hw_addr    (hw_addr),
        .bank_cfg   (bank_cfg),
        .host_ready (host_ready),
        .cs_act     (cs_act),
        .oe_act     (oe_act),
        .we_act     (we_act),
        .capture    (capture),
        .half_idx   (half_idx),
        .act_bank   (act_bank),
        .xfer_wr    (xfer_wr),
        .xfer_word  (xfer_word),
        .half_addr  (half_addr)
    );

    stmem_datapath #(.BANK_BIT(BANK_BIT)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .host_wdata (host_wdata),
        .half_addr  (half_addr),
        .half_idx   (half_idx),
        .xfer_word  (xfer_word),
        .capture    (capture),
        .mem_din    (mem_din),
        .mem_addr   (mem_addr),
        .mem_dout   (mem_dout),
        .host_rdata (host_rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        assign mem_cs_n[b] = !(cs_act && (act_bank == BSEL_W'(b)));
    end

    assign mem_oe_n    = !oe_act;
    assign mem_we_n    = !we_act;
    assign mem_dout_en = cs_act && xfer_wr;

endmodule

// File: rtl/stmem_chk.sv
module stmem_chk
    import stmem_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 host_req,
    input logic                 host_ready,
    input logic [NUM_BANKS-1:0] mem_cs_n,
    input logic                 mem_oe_n,
    input logic                 mem_we_n,
    input logic                 mem_dout_en
);

    localparam int MAX_RUN = (1 << WS_W) + 1;

    logic [CNT_W:0] run_len;
    logic           cs_any;

    assign cs_any = (mem_cs_n != '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (cs_any) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (host_ready && (mem_cs_n == '1) && mem_oe_n && mem_we_n));

    // R3
    one_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cs_any |-> (run_len < (CNT_W+1)'(MAX_RUN)));

    // R5
    oe_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_any |-> mem_oe_n);

    // R6
    we_with_data_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_dout_en && cs_any && mem_oe_n));

    // R9
    stall_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ready) |=> !host_ready);

    // R10
    no_bank_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_any && ($past(mem_cs_n) != '1)) |-> (mem_cs_n == $past(mem_cs_n)));

endmodule

bind stmem_ctrl stmem_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_ready  (host_ready),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dout_en (mem_dout_en)
);

// File: tb/stmem_ctrl_test.sv
module stmem_ctrl_test;

    localparam int BB = 20;
    localparam int MA = BB - 1;

    typedef struct packed {
        int bank;
        int len;
        int oe_first;
        int we_first;
        int we_cnt;
        int addr;
        int wr;
        int data;
    } half_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [0:0]    cfg_bank = '0;
    logic [1:0]    cfg_field = '0;
    logic [4:0]    cfg_wdata = '0;
    logic [4:0]    cfg_rdata;
    logic          host_req = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_word = 1'b0;
    logic [BB:1]   host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic          host_ready;
    logic [31:0]   host_rdata;
    logic [1:0]    mem_cs_n;
    logic          mem_oe_n, mem_we_n, mem_dout_en;
    logic [MA-1:0] mem_addr;
    logic [15:0]   mem_dout, mem_din;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int sh_rd [2] = '{31, 31};
    int sh_wr [2] = '{31, 31};
    int sh_oe [2] = '{0, 0};
    half_t exp_q [$];

    always #2 clk = ~clk;

    stmem_ctrl #(.BANK_BIT(BB)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_bank(cfg_bank),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_req(host_req), .host_wr(host_wr), .host_word(host_word),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    function automatic logic [15:0] mval(input int b, input logic [MA-1:0] a);
        logic [15:0] lo;
        lo = a[15:0];
        return 16'h5A00 ^ ((b != 0) ? 16'h8300 : 16'h0000) ^ 16'(lo * 16'd7);
    endfunction

    assign mem_din = mval((mem_cs_n == 2'b01) ? 1 : 0, mem_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: rebuilds each external cycle and compares it to the scoreboard
    bit       in_cyc = 0;
    half_t    cur;
    logic [1:0] cur_cs;
    logic [MA-1:0] cur_addr;
    logic [15:0] cur_dout;

    always @(negedge clk) begin
        if (rst) begin
            in_cyc = 0;
        end else if (mem_cs_n != 2'b11) begin
            if (!in_cyc) begin
                in_cyc = 1;
                cur = '0;
                cur_cs = mem_cs_n;
                cur_addr = mem_addr;
                cur_dout = mem_dout;
                cur.bank = (mem_cs_n == 2'b10) ? 0 : 1;
                cur.addr = int'(mem_addr);
                cur.wr = mem_dout_en ? 1 : 0;
                cur.data = int'(mem_dout);
                cur.oe_first = -1;
                cur.we_first = -1;
            end else if (mem_cs_n != cur_cs || mem_addr != cur_addr ||
                         (cur.wr != 0 && (mem_dout != cur_dout || !mem_dout_en))) begin
                check(0, "R6", "pins changed inside chip-select", mem_cs_n, cur_cs);
            end
            if (!mem_oe_n && cur.oe_first < 0) cur.oe_first = cur.len;
            if (!mem_we_n) begin
                if (cur.we_first < 0) cur.we_first = cur.len;
                cur.we_cnt++;
            end
            cur.len++;
        end else begin
            if (!mem_oe_n || !mem_we_n)
                check(0, "R5", "strobe low with chip-select high", {mem_oe_n, mem_we_n}, 2'b11);
            if (in_cyc) begin
                half_t e;
                in_cyc = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R7", "unexpected external cycle", cur.addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(cur.bank == e.bank, "R3", "bank", cur.bank, e.bank);
                    check(cur.len == e.len, e.wr != 0 ? "R6" : "R4", "cs length", cur.len, e.len);
                    check(cur.oe_first == e.oe_first, "R5", "oe start", cur.oe_first, e.oe_first);
                    check(cur.we_first == e.we_first && cur.we_cnt == e.we_cnt, "R6",
                          "we start/count", {cur.we_first, cur.we_cnt}, {e.we_first, e.we_cnt});
                    check(cur.addr == e.addr, "R7", "half address", cur.addr, e.addr);
                    if (e.wr != 0)
                        check(cur.data == e.data, "R8", "write half data", cur.data, e.data);
                end
            end
        end
    end

    task automatic cfg_set(input int b, input int f, input int v);
        cfg_wr = 1; cfg_bank = 1'(b); cfg_field = 2'(f); cfg_wdata = 5'(v);
        @(negedge clk);
        cfg_wr = 0;
        if (f == 0) sh_rd[b] = v & 31;
        if (f == 1) sh_wr[b] = v & 31;
        if (f == 2) sh_oe[b] = v & 15;
    endtask

    task automatic cfg_get(input int b, input int f, output int v);
        cfg_bank = 1'(b); cfg_field = 2'(f);
        #1;
        v = int'(cfg_rdata);
    endtask

    // driver: called in the low clock phase; returns at a negedge with ready high
    task automatic xfer(input int b, input bit wr, input bit word,
                        input int addr, input logic [31:0] wd);
        logic [BB:0] hb;
        logic [MA-1:0] ha [2];
        int n, w, busy;
        logic [31:0] exp_rd;
        hb = BB'(addr) | (b != 0 ? (BB+1)'(1) << BB : '0);
        n = word ? 2 : 1;
        w = wr ? sh_wr[b] : sh_rd[b];
        for (int i = 0; i < n; i++) begin
            half_t e;
            ha[i] = hb[BB-1:1];
            if (word) ha[i][0] = i[0];
            e.bank = b;
            e.len = w + 2;
            e.oe_first = wr ? -1 : sh_oe[b];
            e.we_first = wr ? 1 : -1;
            e.we_cnt = wr ? ((w == 0) ? 1 : w) : 0;
            e.addr = int'(ha[i]);
            e.wr = wr ? 1 : 0;
            e.data = int'(i == 0 ? wd[15:0] : wd[31:16]);
            exp_q.push_back(e);
        end
        exp_rd = word ? {mval(b, ha[1]), mval(b, ha[0])} : {16'h0, mval(b, ha[0])};
        check(host_ready == 1'b1, "R9", "ready before request", host_ready, 1);
        host_req = 1; host_wr = wr; host_word = word; host_addr = hb[BB:1]; host_wdata = wd;
        @(negedge clk);
        host_req = 0;
        busy = 0;
        while (!host_ready && busy < 200) begin
            busy++;
            @(negedge clk);
        end
        check(busy == n * (w + 3), "R9", "stall cycles", busy, n * (w + 3));
        if (!wr) check(host_rdata == exp_rd, "R8", "read merge", host_rdata, exp_rd);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (5) @(negedge clk);
        rst = 0;
        // R1: reset state at the ports
        check(host_ready && mem_cs_n == 2'b11 && mem_oe_n && mem_we_n && !mem_dout_en,
              "R1", "idle pins", {host_ready, mem_cs_n, mem_oe_n, mem_we_n}, 5'b11111);
        for (int b = 0; b < 2; b++) begin
            cfg_get(b, 0, v); check(v == 31, "R1", "read wait reset", v, 31);
            cfg_get(b, 1, v); check(v == 31, "R1", "write wait reset", v, 31);
            cfg_get(b, 2, v); check(v == 0, "R1", "oe delay reset", v, 0);
        end
        @(negedge clk);
        // R2: code 3 holds nothing and disturbs nothing
        cfg_set(0, 3, 5'h0A);
        cfg_get(0, 3, v); check(v == 0, "R2", "field 3 reads zero", v, 0);
        cfg_get(0, 0, v); check(v == 31, "R2", "read wait untouched", v, 31);
        cfg_get(0, 1, v); check(v == 31, "R2", "write wait untouched", v, 31);
        cfg_get(0, 2, v); check(v == 0, "R2", "oe delay untouched", v, 0);
        @(negedge clk);
        // R4 R9: slowest default timing, 16-bit read
        xfer(0, 0, 0, 'h0124, '0);
        // R4 R7 R8: fastest read, 32-bit split
        cfg_set(0, 0, 0);
        cfg_set(0, 2, 0);
        xfer(0, 0, 1, 'h0208, '0);
        // R3 R5: bank 1 with delayed output-enable
        cfg_set(1, 0, 5);
        cfg_set(1, 2, 3);
        cfg_set(1, 1, 0);
        xfer(1, 0, 1, 'h0310, '0);
        // R6 R8: minimum write, 16-bit
        xfer(1, 1, 0, 'h0042, 32'h1234ABCD);
        // R6 R10: longer 32-bit write followed at once by a read on the other bank
        cfg_set(1, 1, 4);
        xfer(1, 1, 1, 'h0500, 32'hCAFEF00D);
        xfer(0, 0, 1, 'h0104, '0);
        // R2: OE delay keeps only its low 4 bits
        cfg_set(0, 0, 15);
        cfg_set(0, 2, 5'h1E);
        cfg_get(0, 2, v); check(v == 14, "R2", "oe delay width", v, 14);
        @(negedge clk);
        xfer(0, 0, 1, 'h0A0C, '0);
        // R7 R8: half-word read at an odd half-word address clears upper bits
        xfer(1, 0, 0, 'h0006, '0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7", "pending external cycles", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule